// File: doc/BRIEF.md
# One-Time Fuse Array Controller

This block fronts a small one-time-programmable fuse array, modelled here as an internal register array. A bank of 32-bit mirror registers holds a working copy of the fuse contents. Software reads the mirrors, or overwrites them to override the sensed values, over a simple register bus that carries data in big-endian byte order.

Two instructions act on the array. One reloads every mirror from the fuses. The other burns the mirror contents into the fuses and then reloads. While an instruction runs, its code stays visible in the instruction register, and software polls that field until it reads zero. A burn times each word with a program pulse whose width in clocks comes from a configuration register. Burns are counted, and once a fixed limit is reached the controller refuses further burns. A status register reports an integrity syndrome computed over a group of secret words.

Top module: `fuse_ctrl`

## Requirements
- R1: After reset the controller reloads on its own. The instruction register reads code 0x01 for exactly 34 clock cycles and then 0x00. Afterwards every mirror equals the blank array (zero), and the configuration register reads 0.
- R2: Bus data is big-endian. Bus bits 31:24 carry register bits 7:0, and the bytes reverse likewise for both writes and reads. The configuration register keeps only register bits 15:0, which hold the pulse width. The instruction register holds the code in register bits 7:0 and the error flag in register bit 8.
- R3: Mirror word k (k = 0..33) is readable and writable at byte address 0x200 + 4k. Any other address, including an unaligned one, reads zero and ignores writes.
- R4: The status register at 0x24 reads the XOR of mirror words 0 through 7, XORed with mirror word 8. A value of zero means the secret words are consistent.
- R5: Writing code 0x01 to the instruction register (0x20) replaces every mirror with the fuse array contents and discards any overrides.
- R6: Writing code 0x02 sets each fuse word to its old value ORed with the matching mirror word, then reloads the mirrors. Fuse bits are never cleared.
- R7: At most 2 burns are accepted after reset. A further burn sets the error flag, completes at once, and leaves the array and the mirrors unchanged.
- R8: A burn requested while the pulse width (0x28) is zero sets the error flag, completes at once, and does not use up a burn.
- R9: Any code other than 0x01 or 0x02 sets the error flag and completes at once. The next instruction write that the controller accepts clears the flag.
- R10: While an instruction runs, writes to the instruction, configuration and mirror registers are ignored.
- R11: A reload keeps its code visible for 34 cycles. A burn keeps code 0x02 visible for 34 × width + 34 cycles. The code field then returns to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; rdata updates on the same edge |
| addr | input | 12 | Byte address |
| wdata | input | 32 | Write data, big-endian |
| rdata | output | 32 | Read data, big-endian, registered |

## Verification
The assertions assume that reset is held for at least one clock edge before the first check, and that the bus strobes are always known values. The bench drives every input on the falling edge and keeps reset high for several cycles at the start. It issues instructions only through the bus, so the sequencer sees only the codes and the busy-time writes that the requirements describe. The burn-limit assertions also assume the limit is never raised at run time, and the bench uses the default limit throughout.

// File: rtl/otpf_pkg.sv
package otpf_pkg;

    localparam int unsigned WORD_W = 32;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_RELOAD,
        SQ_BURN
    } seq_state_e;

    typedef enum logic [2:0] {
        RS_NONE,
        RS_INSTR,
        RS_SECRET,
        RS_CFG,
        RS_MIRROR
    } rd_sel_e;

    localparam logic [7:0] OP_RELOAD = 8'h01;
    localparam logic [7:0] OP_BURN   = 8'h02;

    localparam logic [11:0] ADR_INSTR  = 12'h020;
    localparam logic [11:0] ADR_SECRET = 12'h024;
    localparam logic [11:0] ADR_CFG    = 12'h028;
    localparam logic [11:0] ADR_MIR_LO = 12'h200;

    typedef struct packed {
        logic [22:0] rsvd;
        logic        err;
        logic [7:0]  code;
    } instr_reg_t;

    typedef struct packed {
        logic    instr_we;
        logic    cfg_we;
        logic    mir_we;
        rd_sel_e rsel;
    } bus_dec_t;

    function automatic logic [WORD_W-1:0] swap_bytes(input logic [WORD_W-1:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

endpackage

// File: rtl/otpf_decode.sv
module otpf_decode
    import otpf_pkg::*;
#(
    parameter int unsigned ADDR_W  = 12,
    parameter int unsigned N_WORDS = 34,
    parameter int unsigned IDX_W   = 6
) (
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic              busy,
    output bus_dec_t          dec,
    output logic [IDX_W-1:0]  mir_idx
);

    localparam logic [ADDR_W-1:0] MIR_LO = ADDR_W'(ADR_MIR_LO);
    localparam logic [ADDR_W-1:0] MIR_HI = ADDR_W'(ADR_MIR_LO + 4 * (N_WORDS - 1));

    logic [ADDR_W-1:0] off;
    logic              aligned;
    logic              in_mir;
    logic              hit_instr, hit_secret, hit_cfg;

    always_comb begin
        off        = addr - MIR_LO;
        aligned    = (addr[1:0] == 2'b00);
        in_mir     = aligned && (addr >= MIR_LO) && (addr <= MIR_HI);
        mir_idx    = IDX_W'(off >> 2);
        hit_instr  = (addr == ADDR_W'(ADR_INSTR));
        hit_secret = (addr == ADDR_W'(ADR_SECRET));
        hit_cfg    = (addr == ADDR_W'(ADR_CFG));

        dec.instr_we = wr_en && !busy && hit_instr;
        dec.cfg_we   = wr_en && !busy && hit_cfg;
        dec.mir_we   = wr_en && !busy && in_mir;

        if (!rd_en)          dec.rsel = RS_NONE;
        else if (hit_instr)  dec.rsel = RS_INSTR;
        else if (hit_secret) dec.rsel = RS_SECRET;
        else if (hit_cfg)    dec.rsel = RS_CFG;
        else if (in_mir)     dec.rsel = RS_MIRROR;
        else                 dec.rsel = RS_NONE;
    end

endmodule

// File: rtl/otpf_store.sv
module otpf_store
    import otpf_pkg::*;
#(
    parameter int unsigned N_WORDS      = 34,
    parameter int unsigned IDX_W        = 6,
    parameter int unsigned SECRET_WORDS = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mw_en,
    input  logic [IDX_W-1:0]  mw_idx,
    input  logic [WORD_W-1:0] mw_data,
    input  logic              ld_en,
    input  logic              burn_en,
    input  logic [IDX_W-1:0]  seq_idx,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [WORD_W-1:0] rd_word,
    output logic [WORD_W-1:0] secret_syn
);

    logic [WORD_W-1:0] mirror [N_WORDS];
    logic [WORD_W-1:0] fuse   [N_WORDS];

    for (genvar g = 0; g < N_WORDS; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (rst) begin
                mirror[g] <= '0;
                fuse[g]   <= '0;
            end else begin
                if (ld_en && seq_idx == IDX_W'(g))
                    mirror[g] <= fuse[g];
                else if (mw_en && mw_idx == IDX_W'(g))
                    mirror[g] <= mw_data;
                if (burn_en && seq_idx == IDX_W'(g))
                    fuse[g] <= fuse[g] | mirror[g];
            end
        end
    end

    always_comb begin
        rd_word = '0;
        for (int i = 0; i < N_WORDS; i++)
            if (rd_idx == IDX_W'(i)) rd_word = mirror[i];
    end

    always_comb begin
        secret_syn = mirror[SECRET_WORDS];
        for (int i = 0; i < SECRET_WORDS; i++)
            secret_syn = secret_syn ^ mirror[i];
    end

endmodule

// File: rtl/otpf_seq.sv
module otpf_seq
    import otpf_pkg::*;
#(
    parameter int unsigned N_WORDS    = 34,
    parameter int unsigned IDX_W      = 6,
    parameter int unsigned PW_W       = 16,
    parameter int unsigned PROG_LIMIT = 2,
    parameter int unsigned CNT_W      = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_we,
    input  logic [7:0]       cmd_code,
    input  logic [PW_W-1:0]  pw,
    output logic             busy,
    output logic [7:0]       code,
    output logic             err,
    output logic [IDX_W-1:0] idx,
    output logic             ld_en,
    output logic             burn_en,
    output logic [CNT_W-1:0] burns_used
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

    seq_state_e      state;
    logic [PW_W-1:0] pulse_cnt;
    logic [PW_W-1:0] pw_lat;
    logic            pulse_end;

    always_comb begin
        busy      = (state != SQ_IDLE);
        pulse_end = (pulse_cnt == pw_lat - PW_W'(1));
        ld_en     = (state == SQ_RELOAD);
        burn_en   = (state == SQ_BURN) && pulse_end;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SQ_RELOAD;
            code       <= OP_RELOAD;
            err        <= 1'b0;
            idx        <= '0;
            pulse_cnt  <= '0;
            pw_lat     <= '0;
            burns_used <= '0;
        end else begin
            unique case (state)
                SQ_IDLE: begin
                    if (cmd_we) begin
                        err <= 1'b0;
                        idx <= '0;
                        if (cmd_code == OP_RELOAD) begin
                            state <= SQ_RELOAD;
                            code  <= OP_RELOAD;
                        end else if (cmd_code == OP_BURN) begin
                            if (burns_used >= CNT_W'(PROG_LIMIT) || pw == '0) begin
                                err <= 1'b1;
                            end else begin
                                state      <= SQ_BURN;
                                code       <= OP_BURN;
                                pw_lat     <= pw;
                                pulse_cnt  <= '0;
                                burns_used <= burns_used + CNT_W'(1);
                            end
                        end else begin
                            err <= 1'b1;
                        end
                    end
                end
                SQ_RELOAD: begin
                    if (idx == LAST_IDX) begin
                        state <= SQ_IDLE;
                        code  <= 8'h00;
                        idx   <= '0;
                    end else begin
                        idx <= idx + IDX_W'(1);
                    end
                end
                SQ_BURN: begin
                    if (pulse_end) begin
                        pulse_cnt <= '0;
                        if (idx == LAST_IDX) begin
                            state <= SQ_RELOAD;
                            idx   <= '0;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end else begin
                        pulse_cnt <= pulse_cnt + PW_W'(1);
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/fuse_ctrl.sv
module fuse_ctrl
    import otpf_pkg::*;
#(
    parameter int unsigned ADDR_W       = 12,
    parameter int unsigned N_WORDS      = 34,
    parameter int unsigned SECRET_WORDS = 8,
    parameter int unsigned PW_W         = 16,
    parameter int unsigned DEF_PW       = 0,
    parameter int unsigned PROG_LIMIT   = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata
);

    localparam int unsigned IDX_W = $clog2(N_WORDS);
    localparam int unsigned CNT_W = $clog2(PROG_LIMIT + 1);

    bus_dec_t          dec;
    logic [IDX_W-1:0]  mir_idx;
    logic [WORD_W-1:0] wr_int;
    logic [PW_W-1:0]   pw_q;
    logic              seq_busy;
    logic [7:0]        seq_code;
    logic              seq_err;
    logic [IDX_W-1:0]  seq_idx;
    logic              ld_strobe;
    logic              burn_strobe;
    logic [CNT_W-1:0]  burns_used;
    logic [WORD_W-1:0] mir_word;
    logic [WORD_W-1:0] secret_syn;
    instr_reg_t        instr_view;

    assign wr_int = swap_bytes(wdata);

    otpf_decode #(
        .ADDR_W (ADDR_W),
        .N_WORDS(N_WORDS),
        .IDX_W  (IDX_W)
    ) u_decode (
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .busy   (seq_busy),
        .dec    (dec),
        .mir_idx(mir_idx)
    );

    otpf_seq #(
        .N_WORDS   (N_WORDS),
        .IDX_W     (IDX_W),
        .PW_W      (PW_W),
        .PROG_LIMIT(PROG_LIMIT),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_we    (dec.instr_we),
        .cmd_code  (wr_int[7:0]),
        .pw        (pw_q),
        .busy      (seq_busy),
        .code      (seq_code),
        .err       (seq_err),
        .idx       (seq_idx),
        .ld_en     (ld_strobe),
        .burn_en   (burn_strobe),
        .burns_used(burns_used)
    );

    otpf_store #(
        .N_WORDS     (N_WORDS),
        .IDX_W       (IDX_W),
        .SECRET_WORDS(SECRET_WORDS)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .mw_en     (dec.mir_we),
        .mw_idx    (mir_idx),
        .mw_data   (wr_int),
        .ld_en     (ld_strobe),
        .burn_en   (burn_strobe),
        .seq_idx   (seq_idx),
        .rd_idx    (mir_idx),
        .rd_word   (mir_word),
        .secret_syn(secret_syn)
    );

    always_ff @(posedge clk) begin
        if (rst)             pw_q <= PW_W'(DEF_PW);
        else if (dec.cfg_we) pw_q <= wr_int[PW_W-1:0];
    end

    always_comb begin
        instr_view      = '0;
        instr_view.err  = seq_err;
        instr_view.code = seq_code;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (rd_en) begin
            unique case (dec.rsel)
                RS_INSTR:  rdata <= swap_bytes(instr_view);
                RS_SECRET: rdata <= swap_bytes(secret_syn);
                RS_CFG:    rdata <= swap_bytes(WORD_W'(pw_q));
                RS_MIRROR: rdata <= swap_bytes(mir_word);
                default:   rdata <= '0;
            endcase
        end
    end

endmodule

// File: rtl/otpf_checker.sv
module otpf_checker #(
    parameter int unsigned PROG_LIMIT = 2,
    parameter int unsigned CNT_W      = 2
) (
    input logic             clk,
    input logic             rst,
    input logic             busy,
    input logic [7:0]       code,
    input logic             err,
    input logic             ld_en,
    input logic             burn_en,
    input logic [CNT_W-1:0] burns_used
);

    AST_RESET_RELOAD: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (busy && code == 8'h01)); // R1

    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(ld_en && burn_en)); // R6

    AST_BURN_CAP: assert property (@(posedge clk) disable iff (rst)
        burns_used <= CNT_W'(PROG_LIMIT)); // R7

    AST_BURN_STEP: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && (burns_used != $past(burns_used)) |->
            (burns_used == $past(burns_used) + CNT_W'(1)) && busy && code == 8'h02); // R7

    AST_ERR_IDLE: assert property (@(posedge clk) disable iff (rst)
        err |-> (!busy && code == 8'h00)); // R9

    AST_CODE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) && busy && $past(busy) |-> $stable(code)); // R11

    AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (code == 8'h00)); // R11

endmodule

bind fuse_ctrl otpf_checker #(
    .PROG_LIMIT(PROG_LIMIT),
    .CNT_W     (CNT_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .busy      (seq_busy),
    .code      (seq_code),
    .err       (seq_err),
    .ld_en     (ld_strobe),
    .burn_en   (burn_strobe),
    .burns_used(burns_used)
);

// File: tb/fuse_ctrl_bench.sv
module fuse_ctrl_bench;

    localparam int NW = 34;
    localparam int PW = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [11:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;
    logic [31:0] exp_fuse [NW];

    always #2.5 clk = ~clk;

    fuse_ctrl u_fuse_ctrl (
        .clk  (clk),
        .rst  (rst),
        .wr_en(wr_en),
        .rd_en(rd_en),
        .addr (addr),
        .wdata(wdata),
        .rdata(rdata)
    );

    function automatic logic [31:0] sw(input logic [31:0] v);
        return {v[7:0], v[15:8], v[23:16], v[31:24]};
    endfunction

    function automatic logic [31:0] pat_a(input int i);
        return 32'h0101_0000 ^ (32'(i) * 32'h0000_0403);
    endfunction

    function automatic logic [31:0] pat_b(input int i);
        return 32'h8000_0010 ^ (32'(i) * 32'h0002_1000);
    endfunction

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic poll_done(output int n);
        logic [31:0] v;
        n = 0;
        for (int k = 0; k < 1000; k++) begin
            bus_read(12'h020, v);
            if (v[31:24] == 8'h00) break;
            n++;
        end
    endtask

    task automatic check_mirrors(input string req);
        logic [31:0] v;
        for (int i = 0; i < NW; i++) begin
            bus_read(12'(12'h200 + 4 * i), v);
            check(req, v, sw(exp_fuse[i]));
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] fold;
        int n;

        for (int i = 0; i < NW; i++) exp_fuse[i] = '0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1: automatic reload after reset, code 0x01 visible for 34 cycles
        bus_read(12'h020, v);
        check("R1 reset code", v, sw(32'h0000_0001));
        poll_done(n);
        check("R1 reset reload length", 32'(n + 1), 32'd34);
        check_mirrors("R1 mirrors blank");
        bus_read(12'h028, v);
        check("R1 config reset", v, 32'h0);
        bus_read(12'h024, v);
        check("R1 status reset", v, 32'h0);

        // R2: byte order on the configuration register
        bus_write(12'h028, 32'h0000_000A);
        bus_read(12'h028, v);
        check("R2 low byte lands high", v, 32'h0);
        bus_write(12'h028, 32'h0A00_0000);
        bus_read(12'h028, v);
        check("R2 config readback", v, 32'h0A00_0000);

        // R8: burn with zero width refused
        bus_write(12'h028, 32'h0);
        bus_write(12'h020, sw(32'h0000_0002));
        bus_read(12'h020, v);
        check("R8 zero width error", v, sw(32'h0000_0100));

        // R9: unknown code, then cleared by an accepted reload
        bus_write(12'h020, sw(32'h0000_0007));
        bus_read(12'h020, v);
        check("R9 unknown code error", v, sw(32'h0000_0100));
        bus_write(12'h020, sw(32'h0000_0001));
        bus_read(12'h020, v);
        check("R9 error cleared", v, sw(32'h0000_0001));
        poll_done(n);

        // R3: mirror sweep and unmapped addresses
        for (int i = 0; i < NW; i++) bus_write(12'(12'h200 + 4 * i), sw(~pat_a(i)));
        for (int i = 0; i < NW; i++) begin
            bus_read(12'(12'h200 + 4 * i), v);
            check("R3 mirror readback", v, sw(~pat_a(i)));
        end
        bus_write(12'h288, 32'hFFFF_FFFF);
        bus_read(12'h288, v);
        check("R3 past last word", v, 32'h0);
        bus_read(12'h202, v);
        check("R3 unaligned", v, 32'h0);
        bus_read(12'h1FC, v);
        check("R3 below window", v, 32'h0);

        // R4: secret syndrome
        fold = ~pat_a(8);
        for (int i = 0; i < 8; i++) fold = fold ^ ~pat_a(i);
        bus_read(12'h024, v);
        check("R4 syndrome", v, sw(fold));
        fold = '0;
        for (int i = 0; i < 8; i++) fold = fold ^ ~pat_a(i);
        bus_write(12'h220, sw(fold));
        bus_read(12'h024, v);
        check("R4 consistent", v, 32'h0);

        // R5: reload discards overrides
        bus_write(12'h020, sw(32'h0000_0001));
        poll_done(n);
        check("R5 reload length", 32'(n), 32'd34);
        check_mirrors("R5 mirrors from array");

        // R6, R11: first burn
        bus_write(12'h028, sw(32'(PW)));
        for (int i = 0; i < NW; i++) bus_write(12'(12'h200 + 4 * i), sw(pat_a(i)));
        bus_write(12'h020, sw(32'h0000_0002));
        poll_done(n);
        check("R11 burn length", 32'(n), 32'(NW * PW + NW));
        for (int i = 0; i < NW; i++) exp_fuse[i] = exp_fuse[i] | pat_a(i);
        check_mirrors("R6 first burn");

        // R10: writes during a running reload are ignored
        bus_write(12'h020, sw(32'h0000_0001));
        bus_write(12'h20C, 32'hDEAD_BEEF);
        bus_write(12'h028, 32'h0500_0000);
        bus_write(12'h020, sw(32'h0000_0007));
        poll_done(n);
        bus_read(12'h20C, v);
        check("R10 mirror write ignored", v, sw(exp_fuse[3]));
        bus_read(12'h028, v);
        check("R10 config write ignored", v, sw(32'(PW)));
        bus_read(12'h020, v);
        check("R10 instr write ignored", v, 32'h0);

        // R6: second burn ORs into the array
        for (int i = 0; i < NW; i++) bus_write(12'(12'h200 + 4 * i), sw(pat_b(i)));
        bus_write(12'h020, sw(32'h0000_0002));
        poll_done(n);
        check("R11 second burn length", 32'(n), 32'(NW * PW + NW));
        for (int i = 0; i < NW; i++) exp_fuse[i] = exp_fuse[i] | pat_b(i);
        check_mirrors("R6 OR accumulate");

        // R7: third burn refused
        bus_write(12'h200, 32'hFFFF_FFFF);
        bus_write(12'h020, sw(32'h0000_0002));
        bus_read(12'h020, v);
        check("R7 limit error", v, sw(32'h0000_0100));
        bus_read(12'h200, v);
        check("R7 mirror untouched", v, 32'hFFFF_FFFF);
        bus_write(12'h020, sw(32'h0000_0001));
        poll_done(n);
        check_mirrors("R7 array unchanged");

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule